// File: doc/BRIEF.md
# Ingress Bus-Address Region Mapper

This block sits on the inbound side of an I/O bridge. It checks each incoming bus read or write request against a small table of programmable address windows. Each window starts on a 4 KB boundary and spans a whole number of 4 KB pages. When a request falls inside a window, the block rewrites its address into the target address space and tags it with the window index. A request that falls inside no enabled window is consumed and reported as a miss.

Each window also carries an ordering policy. A policy can hold a read back until earlier writes have finished, or hold every request until the window is fully drained. A third policy keeps writes in order unless the request sets its relaxed-ordering bit. Per-window counters track requests that have been issued but not yet completed. The memory side returns completions, which release the counters. A request that must wait holds `req_ready` low until the condition clears.

Software programs a window with a single write strobe. That write carries the bus base, the length in bytes, the target base and the policy. The block refuses any write with a misaligned or empty range and reports the refusal on `cfg_err`.

Top module: `busmap_ingress`

## Requirements
- R1: After reset no window is enabled, `req_ready` is high, and `out_valid`, `miss` and `cfg_err` are low.
- R2: A configuration write is accepted only if all of the following hold: the low 12 bits of the bus base are zero, the low 12 bits of the length are zero, the low 12 bits of the target base are zero, and the length is nonzero. Otherwise `cfg_err` is high for the one cycle after the write and the window keeps its previous contents.
- R3: A request hits window i when window i is enabled and base ≤ address < base + length.
- R4: One cycle after a hit is accepted, `out_valid` is high. In that cycle `out_addr` equals target base + (address − bus base), `out_region` holds the window index and `out_write` holds the request's write bit.
- R5: When several enabled windows contain the address, the lowest index is chosen.
- R6: A request that hits no window is accepted at once and dropped. In the next cycle `miss` is high for exactly one cycle and `out_valid` stays low.
- R7: Policy code 2'b00 (loose): a write never waits on ordering. A read waits while the window has any write outstanding.
- R8: Policy codes 2'b01 and 2'b11 (strict): any request waits while the window has any request outstanding.
- R9: Policy code 2'b10 (packet-driven): a write with `req_relaxed` low waits while writes are outstanding. A write with `req_relaxed` high does not wait. A read waits while writes are outstanding.
- R10: Each window counts outstanding requests and outstanding writes. An accepted request increments its window's counts. A completion (`cpl_valid`, `cpl_region`, `cpl_write`) decrements them. A waiting request is released in the cycle after the count it waits on reaches zero.
- R11: While a window holds 2^CNT_W − 1 outstanding requests (15 by default), `req_ready` stays low for every request that hits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window configuration write strobe |
| cfg_idx | input | IDX_W | Window to program |
| cfg_en | input | 1 | Enable bit for the window |
| cfg_bus_base | input | ADDR_W | Bus base address of the window |
| cfg_len | input | ADDR_W | Window length in bytes |
| cfg_tgt_base | input | TGT_W | Target base address |
| cfg_mode | input | 2 | Ordering policy code |
| cfg_err | output | 1 | Configuration write refused (one-cycle pulse) |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Request bus address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_relaxed | input | 1 | Relaxed-ordering attribute of the request |
| out_valid | output | 1 | Translated request valid (one cycle) |
| out_addr | output | TGT_W | Translated target address |
| out_region | output | IDX_W | Index of the matching window |
| out_write | output | 1 | Write bit of the translated request |
| miss | output | 1 | Request matched no window (one cycle) |
| cpl_valid | input | 1 | Completion from the memory side |
| cpl_region | input | IDX_W | Window the completion belongs to |
| cpl_write | input | 1 | Completion belongs to a write |

## Verification
Some properties are checked on every cycle. Every issued request must obey its window's policy: a strict window issues only when drained, a read issues only when no write is outstanding, and an ordered packet-mode write issues only when no write is outstanding. A full counter never takes another request. A refused configuration leaves the window unchanged. A stall happens only on a hit, and a miss never coincides with a translated output.

Other behaviour can only be shown by the bench's scenarios. These cover the address arithmetic of translation, the choice among overlapping windows, the exact edges of each window, and the release of a waiting request after a completion.

// File: rtl/busmap_pkg.sv
package busmap_pkg;

   typedef enum logic [1:0] {
      ORD_LOOSE      = 2'b00,
      ORD_STRICT     = 2'b01,
      ORD_PKT        = 2'b10,
      ORD_STRICT_ALT = 2'b11
   } ord_mode_t;

   // Decide whether a request aimed at a window must stall.
   function automatic logic must_wait(ord_mode_t m, logic is_wr, logic rel,
                                      logic wr_idle, logic all_idle, logic full);
      logic w;
      if (full) begin
         w = 1'b1;
      end else begin
         unique case (m)
            ORD_LOOSE: w = !is_wr && !wr_idle;
            ORD_PKT:   w = is_wr ? (!rel && !wr_idle) : !wr_idle;
            default:   w = !all_idle;
         endcase
      end
      return w;
   endfunction

endpackage

// File: rtl/busmap_region.sv
module busmap_region
   import busmap_pkg::*;
#(
   parameter int PG_W  = 20,
   parameter int TPG_W = 28,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sel,
   input  logic             cfg_ok,
   input  logic             cfg_en,
   input  logic [PG_W-1:0]  cfg_base_pg,
   input  logic [PG_W-1:0]  cfg_npg,
   input  logic [TPG_W-1:0] cfg_tgt_pg,
   input  ord_mode_t        cfg_mode,
   input  logic [PG_W-1:0]  req_pg,
   output logic             hit,
   output logic [TPG_W-1:0] xlat_pg,
   output ord_mode_t        mode,
   input  logic             issue,
   input  logic             issue_wr,
   input  logic             issue_rel,
   input  logic             cpl_hit,
   input  logic             cpl_wr,
   output logic             wr_idle,
   output logic             all_idle,
   output logic             all_full
);

   logic             en_q;
   logic [PG_W-1:0]  base_q;
   logic [PG_W-1:0]  npg_q;
   logic [TPG_W-1:0] tgt_q;
   ord_mode_t        mode_q;
   logic [CNT_W-1:0] tot_cnt;
   logic [CNT_W-1:0] wr_cnt;
   logic [PG_W-1:0]  rel_pg;
   logic             load;

   assign load = cfg_sel && cfg_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
         npg_q  <= '0;
         tgt_q  <= '0;
         mode_q <= ORD_LOOSE;
      end else if (load) begin
         en_q   <= cfg_en;
         base_q <= cfg_base_pg;
         npg_q  <= cfg_npg;
         tgt_q  <= cfg_tgt_pg;
         mode_q <= cfg_mode;
      end
   end

   // Page distance into the window; wraps below base, so one compare suffices.
   assign rel_pg  = req_pg - base_q;
   assign hit     = en_q && (rel_pg < npg_q);
   assign xlat_pg = tgt_q + TPG_W'(rel_pg);
   assign mode    = mode_q;

   logic tot_dec, wr_dec, wr_inc;
   assign tot_dec = cpl_hit && (tot_cnt != '0);
   assign wr_dec  = cpl_hit && cpl_wr && (wr_cnt != '0);
   assign wr_inc  = issue && issue_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_cnt <= '0;
         wr_cnt  <= '0;
      end else begin
         tot_cnt <= tot_cnt + CNT_W'(issue) - CNT_W'(tot_dec);
         wr_cnt  <= wr_cnt + CNT_W'(wr_inc) - CNT_W'(wr_dec);
      end
   end

   assign wr_idle  = (wr_cnt == '0);
   assign all_idle = (tot_cnt == '0);
   assign all_full = (tot_cnt == '1);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !all_full);

   assert_strict_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (mode_q == ORD_STRICT || mode_q == ORD_STRICT_ALT)) |-> all_idle);

   assert_read_after_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !issue_wr) |-> wr_idle);

   assert_pkt_write_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && issue_wr && !issue_rel && mode_q == ORD_PKT) |-> wr_idle);

   assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel && !cfg_ok) |=> ($stable(base_q) && $stable(npg_q) && $stable(en_q)));

endmodule

// File: rtl/busmap_pick.sv
module busmap_pick #(
   parameter int N_REG = 8,
   localparam int IDX_W = $clog2(N_REG)
) (
   input  logic [N_REG-1:0] hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N_REG - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

   assign any = |hits;

endmodule

// File: rtl/busmap_ingress.sv
module busmap_ingress
   import busmap_pkg::*;
#(
   parameter int N_REG   = 8,
   parameter int ADDR_W  = 32,
   parameter int TGT_W   = 40,
   parameter int PAGE_LG = 12,
   parameter int CNT_W   = 4,
   localparam int IDX_W  = $clog2(N_REG),
   localparam int PG_W   = ADDR_W - PAGE_LG,
   localparam int TPG_W  = TGT_W - PAGE_LG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] cfg_bus_base,
   input  logic [ADDR_W-1:0] cfg_len,
   input  logic [TGT_W-1:0]  cfg_tgt_base,
   input  logic [1:0]        cfg_mode,
   output logic              cfg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_relaxed,
   output logic              out_valid,
   output logic [TGT_W-1:0]  out_addr,
   output logic [IDX_W-1:0]  out_region,
   output logic              out_write,
   output logic              miss,
   input  logic              cpl_valid,
   input  logic [IDX_W-1:0]  cpl_region,
   input  logic              cpl_write
);

   if (N_REG < 2)          $error("N_REG must be at least 2");
   if (PAGE_LG < 1)        $error("PAGE_LG must be positive");
   if (ADDR_W <= PAGE_LG)  $error("ADDR_W must exceed PAGE_LG");
   if (TGT_W < ADDR_W)     $error("TGT_W must not be narrower than ADDR_W");
   if (CNT_W < 1)          $error("CNT_W must be positive");

   // Configuration check
   logic cfg_ok;
   assign cfg_ok = (cfg_bus_base[PAGE_LG-1:0] == '0) &&
                   (cfg_len[PAGE_LG-1:0] == '0) &&
                   (cfg_tgt_base[PAGE_LG-1:0] == '0) &&
                   (cfg_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= cfg_we && !cfg_ok;
   end

   // Window table
   logic [N_REG-1:0] hits, wr_idle, all_idle, all_full, issue_v;
   logic [TPG_W-1:0] xlat_pg [N_REG];
   ord_mode_t        mode_v  [N_REG];
   logic [PG_W-1:0]  req_pg;
   logic             any_hit;
   logic [IDX_W-1:0] sel;
   logic             accept;

   assign req_pg = req_addr[ADDR_W-1:PAGE_LG];

   for (genvar g = 0; g < N_REG; g++) begin : g_win
      busmap_region #(
         .PG_W  (PG_W),
         .TPG_W (TPG_W),
         .CNT_W (CNT_W)
      ) i_win (
         .clk         (clk),
         .rst_n       (rst_n),
         .cfg_sel     (cfg_we && (cfg_idx == IDX_W'(g))),
         .cfg_ok      (cfg_ok),
         .cfg_en      (cfg_en),
         .cfg_base_pg (cfg_bus_base[ADDR_W-1:PAGE_LG]),
         .cfg_npg     (cfg_len[ADDR_W-1:PAGE_LG]),
         .cfg_tgt_pg  (cfg_tgt_base[TGT_W-1:PAGE_LG]),
         .cfg_mode    (ord_mode_t'(cfg_mode)),
         .req_pg      (req_pg),
         .hit         (hits[g]),
         .xlat_pg     (xlat_pg[g]),
         .mode        (mode_v[g]),
         .issue       (issue_v[g]),
         .issue_wr    (req_write),
         .issue_rel   (req_relaxed),
         .cpl_hit     (cpl_valid && (cpl_region == IDX_W'(g))),
         .cpl_wr      (cpl_write),
         .wr_idle     (wr_idle[g]),
         .all_idle    (all_idle[g]),
         .all_full    (all_full[g])
      );
      assign issue_v[g] = accept && any_hit && (sel == IDX_W'(g));
   end

   busmap_pick #(.N_REG(N_REG)) i_pick (
      .hits (hits),
      .any  (any_hit),
      .idx  (sel)
   );

   // Ordering gate
   logic stall;
   assign stall = any_hit && must_wait(mode_v[sel], req_write, req_relaxed,
                                       wr_idle[sel], all_idle[sel], all_full[sel]);
   assign req_ready = !stall;
   assign accept    = req_valid && req_ready;

   // Output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_region <= '0;
         out_write  <= 1'b0;
         miss       <= 1'b0;
      end else begin
         out_valid <= accept && any_hit;
         miss      <= accept && !any_hit;
         if (accept && any_hit) begin
            out_addr   <= {xlat_pg[sel], req_addr[PAGE_LG-1:0]};
            out_region <= sel;
            out_write  <= req_write;
         end
      end
   end

   assert_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && miss));

   assert_stall_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> any_hit);

endmodule

// File: tb/test_busmap_ingress.sv
module test_busmap_ingress;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 8;
   localparam int AW = 32;
   localparam int TW = 40;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic          cfg_en = 1'b0;
   logic [AW-1:0] cfg_bus_base = '0;
   logic [AW-1:0] cfg_len = '0;
   logic [TW-1:0] cfg_tgt_base = '0;
   logic [1:0]    cfg_mode = '0;
   logic          cfg_err;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_relaxed = 1'b0;
   logic          out_valid;
   logic [TW-1:0] out_addr;
   logic [IW-1:0] out_region;
   logic          out_write;
   logic          miss;
   logic          cpl_valid = 1'b0;
   logic [IW-1:0] cpl_region = '0;
   logic          cpl_write = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   busmap_ingress i_busmap_ingress (.*);

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Bench view of the window table
   logic [AW-1:0] m_base [NR];
   logic [AW-1:0] m_len  [NR];
   logic [TW-1:0] m_tgt  [NR];
   bit            m_en   [NR];

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lookup(input logic [AW-1:0] a);
      int r = -1;
      for (int i = NR - 1; i >= 0; i--)
         if (m_en[i] && a >= m_base[i] && {1'b0, a} < {1'b0, m_base[i]} + {1'b0, m_len[i]}) r = i;
      return r;
   endfunction

   task automatic cfg(input int idx, input bit en, input logic [AW-1:0] base,
                      input logic [AW-1:0] len, input logic [TW-1:0] tgt, input logic [1:0] mode);
      bit good;
      good = (base[11:0] == 0) && (len[11:0] == 0) && (tgt[11:0] == 0) && (len != 0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en;
      cfg_bus_base = base; cfg_len = len; cfg_tgt_base = tgt; cfg_mode = mode;
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_err == !good, "R2 cfg_err", 64'(cfg_err), 64'(!good));
      if (good) begin
         m_en[idx] = en; m_base[idx] = base; m_len[idx] = len; m_tgt[idx] = tgt;
      end
   endtask

   // Full request: expects to be accepted at once.
   task automatic send(input logic [AW-1:0] a, input bit wr, input bit rel, input string tag);
      int r;
      logic [TW-1:0] ea;
      r = lookup(a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_relaxed = rel;
      #1;
      check(req_ready == 1'b1, {tag, " ready"}, 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      if (r < 0) begin
         check(miss == 1'b1 && out_valid == 1'b0, "R6 miss pulse",
               64'({miss, out_valid}), 64'b10);
         @(negedge clk);
         check(miss == 1'b0, "R6 miss one cycle", 64'(miss), 64'd0);
      end else begin
         ea = m_tgt[r] + TW'(a - m_base[r]);
         check(out_valid && !miss, {tag, " out_valid"}, 64'({out_valid, miss}), 64'b10);
         check(out_addr == ea, {tag, " out_addr"}, 64'(out_addr), 64'(ea));
         check(out_region == IW'(r) && out_write == wr, {tag, " region/write"},
               64'({out_region, out_write}), 64'({IW'(r), wr}));
      end
   endtask

   // Look at ready without letting the request be taken.
   task automatic probe(input logic [AW-1:0] a, input bit wr, input bit rel,
                        input bit exp_rdy, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_relaxed = rel;
      #1;
      check(req_ready == exp_rdy, tag, 64'(req_ready), 64'(exp_rdy));
      req_valid = 1'b0;
   endtask

   task automatic cpl(input int r, input bit wr);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_region = IW'(r); cpl_write = wr;
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_en[i] = 0; m_base[i] = '0; m_len[i] = '0; m_tgt[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready && !out_valid && !miss && !cfg_err, "R1 reset outputs",
            64'({req_ready, out_valid, miss, cfg_err}), 64'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      send(32'h0001_0000, 1'b0, 1'b0, "R1 no window after reset");

      // Window table: overlap of w0 and w1 on pages 0x12-0x13
      cfg(0, 1, 32'h0001_0000, 32'h0000_4000, 40'h12_3400_0000, 2'b00);
      cfg(1, 1, 32'h0001_2000, 32'h0000_4000, 40'h00_5000_0000, 2'b01);
      cfg(2, 1, 32'h0002_0000, 32'h0000_1000, 40'h01_0000_0000, 2'b10);
      cfg(3, 1, 32'h0003_0000, 32'h0000_2000, 40'hAB_CDE0_0000, 2'b11);

      // R3 R4 R5 sweep over pages 0x0f..0x33, completing each hit
      for (int p = 'h0f; p <= 'h33; p++) begin
         logic [AW-1:0] a;
         int r;
         a = AW'(p << 12) | AW'((p * 'h1a4) & 'hfff);
         r = lookup(a);
         send(a, 1'b0, 1'b0, "R3 R4 R5 sweep");
         if (r >= 0) cpl(r, 1'b0);
      end
      // R3 window edges
      send(32'h0001_0000, 1'b0, 1'b0, "R3 first byte");  cpl(0, 0);
      send(32'h0001_5fff, 1'b0, 1'b0, "R3 last byte w1"); cpl(1, 0);
      send(32'h0001_6000, 1'b0, 1'b0, "R3 one past w1");
      send(32'h0002_0fff, 1'b1, 1'b0, "R4 write w2");     cpl(2, 1);

      // R2 refused writes leave window 4 disabled
      cfg(4, 1, 32'h0004_0800, 32'h0000_1000, 40'h0, 2'b00);
      cfg(4, 1, 32'h0004_0000, 32'h0000_1800, 40'h0, 2'b00);
      cfg(4, 1, 32'h0004_0000, 32'h0000_0000, 40'h0, 2'b00);
      cfg(4, 1, 32'h0004_0000, 32'h0000_1000, 40'h0000_0010, 2'b00);
      send(32'h0004_0010, 1'b0, 1'b0, "R2 refused window stays off");
      cfg(4, 1, 32'h0004_0000, 32'h0000_1000, 40'h77_0000_0000, 2'b00);
      send(32'h0004_0010, 1'b0, 1'b0, "R2 accepted window"); cpl(4, 0);
      cfg(4, 0, 32'h0004_0000, 32'h0000_1000, 40'h0, 2'b00);
      send(32'h0004_0010, 1'b0, 1'b0, "R2 disabled again");

      // R7 loose (window 0)
      send(32'h0001_0100, 1'b1, 1'b0, "R7 write 1");
      send(32'h0001_0200, 1'b1, 1'b0, "R7 write 2 not held");
      probe(32'h0001_0300, 1'b0, 1'b0, 1'b0, "R7 read held behind writes");
      cpl(0, 1);
      probe(32'h0001_0300, 1'b0, 1'b0, 1'b0, "R7 read held one write left");
      cpl(0, 1);
      probe(32'h0001_0300, 1'b0, 1'b0, 1'b1, "R10 read released");
      send(32'h0001_0300, 1'b0, 1'b0, "R7 read");
      send(32'h0001_0400, 1'b1, 1'b0, "R7 write past read");
      cpl(0, 0); cpl(0, 1);

      // R8 strict (window 1 page 0x14, window 3 code 11)
      send(32'h0001_4000, 1'b0, 1'b0, "R8 read");
      probe(32'h0001_4040, 1'b0, 1'b0, 1'b0, "R8 read held");
      probe(32'h0001_4040, 1'b1, 1'b1, 1'b0, "R8 write held");
      cpl(1, 0);
      probe(32'h0001_4040, 1'b1, 1'b0, 1'b1, "R8 released");
      send(32'h0003_1000, 1'b1, 1'b0, "R8 alt write");
      probe(32'h0003_1008, 1'b1, 1'b0, 1'b0, "R8 alt code holds");
      cpl(3, 1);
      probe(32'h0003_1008, 1'b0, 1'b0, 1'b1, "R8 alt released");

      // R9 packet-driven (window 2)
      send(32'h0002_0010, 1'b1, 1'b0, "R9 ordered write");
      probe(32'h0002_0020, 1'b1, 1'b0, 1'b0, "R9 ordered write held");
      probe(32'h0002_0020, 1'b1, 1'b1, 1'b1, "R9 relaxed write passes");
      send(32'h0002_0020, 1'b1, 1'b1, "R9 relaxed write");
      probe(32'h0002_0030, 1'b0, 1'b0, 1'b0, "R9 read held");
      cpl(2, 1); cpl(2, 1);
      probe(32'h0002_0030, 1'b1, 1'b0, 1'b1, "R9 ordered released");

      // R11 saturation on window 0
      for (int k = 0; k < 15; k++) send(32'h0001_1000, 1'b1, 1'b0, "R11 fill");
      probe(32'h0001_1000, 1'b1, 1'b0, 1'b0, "R11 full holds write");
      probe(32'h0001_6000, 1'b0, 1'b0, 1'b1, "R11 other address free");
      for (int k = 0; k < 15; k++) cpl(0, 1);
      probe(32'h0001_1000, 1'b0, 1'b0, 1'b1, "R11 R10 drained");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule